// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the slave side of a serial flash read path. It sits behind four
pins (an active-low chip enable, a serial clock, a serial data input and a
serial data output with a separate enable) and answers a single command: a
fast read. The host lowers chip enable and clocks in an eight-bit command, a
24-bit start address and one throw-away byte. The block then returns bytes
from its storage without a break for as long as chip enable stays low. The
read pointer moves forward by one after every byte.

All pins are sampled in the block's own system clock domain through
synchronizer stages. The serial clock must therefore run well below the system
clock: at least four system cycles per serial half period with the default two
synchronizer stages. Storage is a read-only array of 2^LOC_W bytes with a
registered read port. Its content is a fixed, computed pattern, so the data
path can be checked without a load interface.

Top module: `frd_responder`

## Requirements
- R1: A read starts only when the first eight bits after chip enable falls equal 0x0B. These bits are sampled on rising serial clock edges, most significant bit first.
- R2: The next 24 bits form the start address, most significant bit first. Only the low 19 bits select a location; bits 23 to 19 have no effect on the data returned.
- R3: The eight bits after the address are a dummy byte. Their values have no effect on the data returned.
- R4: The first data bit is driven on the falling serial clock edge that follows the 40th rising edge. The host therefore samples it on the 41st rising edge.
- R5: `so_oe` is 0 after reset and throughout the command, address and dummy phases.
- R6: Each data byte leaves most significant bit first. `so` changes only after a falling serial clock edge.
- R7: Bytes come from consecutive locations, starting at the start address, with no limit on the stream length.
- R8: After location 0x7FFFF, the next byte comes from location 0x00000.
- R9: A rise of chip enable ends the transfer. `so_oe` returns to 0 within SYNC_STAGES+3 system cycles, and the next fall of chip enable starts a new command.
- R10: The serial clock may idle low or high when chip enable falls (modes 0 and 3). Both give identical results.
- R11: If the command byte is any value other than 0x0B, `so_oe` stays 0 until chip enable rises.
- R12: The byte stored at location a equals a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 0xA5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip enable, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for so; 0 means high impedance |

## Verification
A bit counter that slips shows up in the very first data byte: the byte arrives rotated or taken from a shifted address, so the scoreboard compares every byte in the cycle it completes. A read pointer that fails to step or to wrap breaks the byte sequence at the exact boundary. Those boundaries are exercised directly, at the top of the 19-bit space and with the upper address bits set. If the enable control goes wrong, `so_oe` is seen high on a header clock or after chip enable rises. The bench samples this on every serial rising edge of each header and within a few system cycles of the end of each transfer.

// File: rtl/frd_pkg.sv
package frd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_REJECT
  } frd_phase_e;

  // Storage content: XOR fold of the location bytes, offset by 0xA5.
  function automatic logic [7:0] frd_pattern(input logic [31:0] loc);
    return loc[7:0] ^ loc[15:8] ^ loc[23:16] ^ loc[31:24] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/frd_pin_sync.sv
module frd_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign lvl_o = stg[STAGES-1];

endmodule

// File: rtl/frd_cmd_fsm.sv
module frd_cmd_fsm
  import frd_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          LOC_W      = 19,
  parameter int          DUMMY_BITS = 8,
  parameter logic [7:0]  OPCODE     = 8'h0B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_hi,
  input  logic             sck_rise,
  input  logic             si_s,
  output frd_phase_e       phase,
  output logic             addr_vld,
  output logic [LOC_W-1:0] addr
);

  localparam int CNT_W = $clog2(ADDR_W);

  logic [CNT_W-1:0] cnt;
  logic [LOC_W-2:0] sh;
  logic [LOC_W-1:0] nxt;
  logic [7:0]       opc_q;

  assign nxt = {sh, si_s};

  always_ff @(posedge clk) begin
    addr_vld <= 1'b0;
    if (rst || cs_hi) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      sh    <= '0;
      opc_q <= '0;
      addr  <= '0;
    end else begin
      case (phase)
        PH_IDLE: phase <= PH_OPC;
        PH_OPC, PH_ADDR, PH_DUMMY: begin
          if (sck_rise) begin
            sh  <= nxt[LOC_W-2:0];
            cnt <= cnt + 1'b1;
            if (phase == PH_OPC && cnt == CNT_W'(7)) begin
              opc_q <= nxt[7:0];
              phase <= (nxt[7:0] == OPCODE) ? PH_ADDR : PH_REJECT;
              cnt   <= '0;
            end else if (phase == PH_ADDR && cnt == CNT_W'(ADDR_W - 1)) begin
              addr     <= nxt;
              addr_vld <= 1'b1;
              phase    <= PH_DUMMY;
              cnt      <= '0;
            end else if (phase == PH_DUMMY && cnt == CNT_W'(DUMMY_BITS - 1)) begin
              phase <= PH_DATA;
              cnt   <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  addr_opc_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) |-> (opc_q == OPCODE));

  // R11
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REJECT) |=> (phase == PH_REJECT || phase == PH_IDLE));

endmodule

// File: rtl/frd_store.sv
module frd_store
  import frd_pkg::*;
#(
  parameter int LOC_W = 19
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [LOC_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= frd_pattern(32'(rd_addr));
  end

endmodule

// File: rtl/frd_tx.sv
module frd_tx
  import frd_pkg::*;
#(
  parameter int LOC_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  frd_phase_e       phase,
  input  logic             sck_fall,
  input  logic             addr_vld,
  input  logic [LOC_W-1:0] addr,
  input  logic [7:0]       rd_data,
  output logic             rd_en,
  output logic [LOC_W-1:0] rd_addr,
  output logic             so,
  output logic             so_oe
);

  logic [2:0] bidx;
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    rd_en <= 1'b0;
    if (rst) begin
      rd_addr <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
      bidx    <= '0;
      sh      <= '0;
    end else if (phase != PH_DATA) begin
      so_oe <= 1'b0;
      bidx  <= '0;
      if (addr_vld) begin
        rd_addr <= addr;
        rd_en   <= 1'b1;
      end
    end else if (sck_fall) begin
      so_oe <= 1'b1;
      bidx  <= bidx + 1'b1;
      if (bidx == 3'd0) begin
        so      <= rd_data[7];
        sh      <= {rd_data[6:0], 1'b0};
        rd_addr <= rd_addr + 1'b1;
        rd_en   <= 1'b1;
      end else begin
        so <= sh[7];
        sh <= {sh[6:0], 1'b0};
      end
    end
  end

  // R6
  so_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(so));

endmodule

// File: rtl/frd_responder.sv
module frd_responder
  import frd_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         LOC_W       = 19,
  parameter int         DUMMY_BITS  = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPCODE      = 8'h0B
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);

  logic [2:0]       pins_s;
  logic             cs_s, sck_s, si_s, sck_prev;
  logic             sck_rise, sck_fall;
  frd_phase_e       phase;
  logic             addr_vld, rd_en;
  logic [LOC_W-1:0] addr, rd_addr;
  logic [7:0]       rd_data;

  frd_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .pin_i({cs_n, sck, si}), .lvl_o(pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev & ~cs_s;
  assign sck_fall = ~sck_s & sck_prev & ~cs_s;

  frd_cmd_fsm #(
    .ADDR_W(ADDR_W), .LOC_W(LOC_W), .DUMMY_BITS(DUMMY_BITS), .OPCODE(OPCODE)
  ) u_fsm (
    .clk(clk), .rst(rst), .cs_hi(cs_s), .sck_rise(sck_rise), .si_s(si_s),
    .phase(phase), .addr_vld(addr_vld), .addr(addr)
  );

  frd_store #(.LOC_W(LOC_W)) u_store (
    .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  frd_tx #(.LOC_W(LOC_W)) u_tx (
    .clk(clk), .rst(rst), .phase(phase), .sck_fall(sck_fall),
    .addr_vld(addr_vld), .addr(addr), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .so(so), .so_oe(so_oe)
  );

  // R5
  hdr_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_DATA && $past(phase) != PH_DATA) |-> !so_oe);

  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> (phase == PH_DATA));

  // R9
  cs_end_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s) && $past(cs_s, 2)) |-> !so_oe);

endmodule

// File: tb/frd_responder_tb.sv
module frd_responder_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  string cur_req = "R7";
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  frd_responder u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] ref_byte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: collects one bit per serial rising edge, compares whole bytes.
  logic [7:0] mon_sh;
  int mon_cnt = 0;
  bit mon_oe_ok = 1'b1;
  always @(posedge sck) begin
    if (mon_en) begin
      if (so_oe !== 1'b1) mon_oe_ok = 1'b0;
      mon_sh = {mon_sh[6:0], so};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, mon_sh, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_oe_ok && mon_sh === e, cur_req, mon_sh, e);
        end
        mon_oe_ok = 1'b1;
      end
    end
  end

  task automatic start_xfer(input bit mode3);
    sck = mode3;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  // Sends one byte; R5 / R11: enable must stay low at every rising edge.
  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si = b[i];
      tick(HALF);
      check(so_oe === 1'b0, req, so_oe, 0);
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic recv(input int nbytes);
    mon_en = 1'b1;
    for (int i = 0; i < nbytes * 8; i++) begin
      sck = 1'b0;
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
    end
    mon_en = 1'b0;
  endtask

  task automatic end_xfer(input bit mode3);
    if (!mode3) sck = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(5);
    check(so_oe === 1'b0, "R9", so_oe, 0);
    tick(HALF * 2);
  endtask

  // Driver: pushes expected bytes, then runs a full read transaction.
  task automatic read_run(input bit mode3, input logic [23:0] a, input logic [7:0] dummy,
                          input int nbytes, input string req);
    cur_req = req;
    for (int i = 0; i < nbytes; i++) exp_q.push_back(ref_byte(a[18:0] + 19'(i)));
    start_xfer(mode3);
    send_byte(8'h0B, "R5");
    send_byte(a[23:16], "R5");
    send_byte(a[15:8], "R5");
    send_byte(a[7:0], "R5");
    send_byte(dummy, "R5");
    recv(nbytes);
    end_xfer(mode3);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(4);
    // R5: reset state
    check(so_oe === 1'b0, "R5", so_oe, 0);
    // R1 R4 R6 R7 R12: mode 0 basic read
    read_run(1'b0, 24'h001234, 8'h00, 6, "R1 R4 R6 R7 R12");
    // R10: same read in mode 3
    read_run(1'b1, 24'h001234, 8'h00, 6, "R10");
    // R3: dummy of all ones gives the same data
    read_run(1'b0, 24'h012345, 8'hFF, 4, "R3");
    read_run(1'b1, 24'h012345, 8'h5A, 4, "R3");
    // R2: upper address bits ignored
    read_run(1'b0, 24'hF81234, 8'h00, 4, "R2");
    read_run(1'b0, 24'h7ABCDE, 8'h00, 3, "R2");
    // R8: wrap from top of the space
    read_run(1'b1, 24'h07FFFD, 8'h00, 5, "R8");
    // R7: long stream across a 256-byte boundary
    read_run(1'b0, 24'h0000F8, 8'hC3, 24, "R7");
    // R11: wrong command keeps output off
    start_xfer(1'b0);
    send_byte(8'h03, "R11");
    for (int i = 0; i < 6; i++) send_byte(8'hA0 + 8'(i), "R11");
    end_xfer(1'b0);
    // R9: next transaction after a reject and after a cut-short stream
    read_run(1'b0, 24'h000010, 8'h00, 2, "R9");
    cur_req = "R9";
    exp_q.push_back(ref_byte(19'h00200));
    start_xfer(1'b0);
    send_byte(8'h0B, "R5");
    send_byte(8'h00, "R5");
    send_byte(8'h02, "R5");
    send_byte(8'h00, "R5");
    send_byte(8'h00, "R5");
    recv(1);
    sck = 1'b0;
    tick(HALF);
    sck = 1'b1;
    tick(HALF);
    end_xfer(1'b0);
    read_run(1'b1, 24'h000300, 8'h00, 2, "R9");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule